// File: doc/BRIEF.md
# SPI Serial Clock Rate Generator

This block produces the serial clock reference for an SPI master from the bus clock. It holds one 8-bit rate register. The register has a 3-bit linear prescale field and a 3-bit power-of-two field. The bus clock is divided by the product of the two stages, which gives divisors from 2 up to 2048. The block outputs a square wave at the divided rate with a 50% duty cycle. It also outputs a single-cycle tick once per full serial clock period, which the shift logic can use to advance.

A run input enables the divider. While run is low, the divider is held at zero and the clock reference stays low. The register can be read or written at any time. Every write restarts the divider from zero, so the new rate starts from a known phase, even in the middle of a transfer.

Top module: `sck_rate_gen`

## Requirements
- R1: With prescale field value P and power field value S, the period of `sck_ref` is (P+1)·2^(S+1) bus clock cycles.
- R2: A write stores `wr_data[6:4]` as P and `wr_data[2:0]` as S. From the next cycle on, `rd_data` returns P in bits 6:4 and S in bits 2:0.
- R3: Bits 7 and 3 of `rd_data` always read 0, whatever is written to them.
- R4: Reset clears the register to 0, so `rd_data` reads 0x00 and the period is 2 cycles.
- R5: A register write restarts the divider. `sck_ref` is low in the cycle after the write, and its first rise comes (P+1)·2^S cycles after the write edge.
- R6: `sck_ref` is high for (P+1)·2^S cycles and then low for (P+1)·2^S cycles.
- R7: `baud_tick` pulses for exactly one cycle per `sck_ref` period. It is high in the same cycle that `sck_ref` has just fallen.
- R8: While `run` is low, `sck_ref` and `baud_tick` stay low. After `run` rises, the first rise of `sck_ref` is seen (P+1)·2^S cycles after the negedge at which `run` was driven high.
- R9: Reads and writes take effect whether or not `run` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| run | input | 1 | Master enable / transfer active |
| rd_data | output | 8 | Register read data |
| baud_tick | output | 1 | One-cycle pulse per divided period |
| sck_ref | output | 1 | 50% duty clock reference at the divided rate |

## Verification
The assertions check the following on every cycle:
- Both counters stay within their limits.
- The register read value follows each write with the reserved bits cleared.
- A write or a low `run` leaves `sck_ref` and the tick low in the following cycle.
- Each tick lines up with a falling edge of `sck_ref`.

The following can only be shown by the bench's scenarios:
- The actual period and high time for all 64 field combinations.
- The distance from a write, or from raising `run`, to the first rising edge.
- The tick count per period.

// File: rtl/sckgen_pkg.sv
package sckgen_pkg;

    localparam int REG_W    = 8;
    localparam int PRE_W    = 3;
    localparam int RATE_W   = 3;
    localparam int PRE_LSB  = 4;
    localparam int RATE_LSB = 0;
    localparam int POW_W    = (1 << RATE_W) - 1;

    typedef struct packed {
        logic [PRE_W-1:0]  pre;
        logic [RATE_W-1:0] rate;
    } baud_cfg_t;

    typedef enum logic {
        SCK_LO = 1'b0,
        SCK_HI = 1'b1
    } sck_phase_t;

    function automatic baud_cfg_t decode_wr(input logic [REG_W-1:0] d);
        baud_cfg_t c;
        c.pre  = d[PRE_LSB +: PRE_W];
        c.rate = d[RATE_LSB +: RATE_W];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] encode_rd(input baud_cfg_t c);
        logic [REG_W-1:0] r;
        r = '0;
        r[PRE_LSB +: PRE_W]   = c.pre;
        r[RATE_LSB +: RATE_W] = c.rate;
        return r;
    endfunction

    // terminal count of the power-of-two stage: 2^s - 1
    function automatic logic [POW_W-1:0] pow_limit(input logic [RATE_W-1:0] s);
        return {POW_W{1'b1}} >> (POW_W - int'(s));
    endfunction

endpackage

// File: rtl/sckgen_reg.sv
module sckgen_reg
    import sckgen_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output baud_cfg_t        cfg,
    output logic [REG_W-1:0] rd_data
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (wr_en) begin
            cfg <= decode_wr(wr_data);
        end
    end

    assign rd_data = encode_rd(cfg);

    AST_REG_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (rd_data[PRE_LSB +: PRE_W] == $past(wr_data[PRE_LSB +: PRE_W])
                   && rd_data[RATE_LSB +: RATE_W] == $past(wr_data[RATE_LSB +: RATE_W]))); // R2

    AST_REG_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(rd_data)); // R9

endmodule

// File: rtl/sckgen_prescale.sv
module sckgen_prescale
    import sckgen_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic [PRE_W-1:0] pre_max,
    output logic             pre_en
);

    logic [PRE_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt <= '0;
        end else if (cnt == pre_max) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign pre_en = !clear && (cnt == pre_max);

    AST_PRE_BOUND: assert property (@(posedge clk) disable iff (rst)
        $stable(pre_max) |-> cnt <= pre_max); // R1

    AST_PRE_CLEARED: assert property (@(posedge clk) disable iff (rst)
        clear |=> cnt == '0); // R5

endmodule

// File: rtl/sckgen_pow2.sv
module sckgen_pow2
    import sckgen_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              pre_en,
    input  logic [RATE_W-1:0] rate,
    output logic              sck_ref,
    output logic              baud_tick
);

    logic [POW_W-1:0] cnt;
    logic [POW_W-1:0] lim;
    sck_phase_t       phase;

    assign lim = pow_limit(rate);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt       <= '0;
            phase     <= SCK_LO;
            baud_tick <= 1'b0;
        end else begin
            baud_tick <= 1'b0;
            if (pre_en) begin
                if (cnt == lim) begin
                    cnt       <= '0;
                    phase     <= (phase == SCK_HI) ? SCK_LO : SCK_HI;
                    baud_tick <= (phase == SCK_HI);
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    assign sck_ref = (phase == SCK_HI);

    AST_POW_BOUND: assert property (@(posedge clk) disable iff (rst)
        $stable(rate) |-> cnt <= lim); // R1

    AST_TICK_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        baud_tick |-> $fell(sck_ref)); // R7

    AST_SCK_STEADY: assert property (@(posedge clk) disable iff (rst)
        (!pre_en && !clear) |=> $stable(sck_ref)); // R6

endmodule

// File: rtl/sck_rate_gen.sv
module sck_rate_gen
    import sckgen_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             run,
    output logic [REG_W-1:0] rd_data,
    output logic             baud_tick,
    output logic             sck_ref
);

    baud_cfg_t cfg;
    logic      clear;
    logic      pre_en;

    assign clear = wr_en || !run;

    sckgen_reg u_reg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .cfg     (cfg),
        .rd_data (rd_data)
    );

    sckgen_prescale u_pre (
        .clk     (clk),
        .rst     (rst),
        .clear   (clear),
        .pre_max (cfg.pre),
        .pre_en  (pre_en)
    );

    sckgen_pow2 u_pow (
        .clk       (clk),
        .rst       (rst),
        .clear     (clear),
        .pre_en    (pre_en),
        .rate      (cfg.rate),
        .sck_ref   (sck_ref),
        .baud_tick (baud_tick)
    );

    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
        !run |=> (!sck_ref && !baud_tick)); // R8

    AST_WRITE_RESTART: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !sck_ref); // R5

    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (rd_data[7] == 1'b0 && rd_data[3] == 1'b0)); // R3

endmodule

// File: tb/sck_rate_gen_bench.sv
module sck_rate_gen_bench;

    logic       clk = 1'b0;
    logic       rst;
    logic       wr_en;
    logic [7:0] wr_data;
    logic       run;
    logic [7:0] rd_data;
    logic       baud_tick;
    logic       sck_ref;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    sck_rate_gen u_sck_rate_gen (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .run       (run),
        .rd_data   (rd_data),
        .baud_tick (baud_tick),
        .sck_ref   (sck_ref)
    );

    function automatic int half_of(input int p, input int s);
        return (p + 1) << s;
    endfunction

    function automatic logic [7:0] exp_rd(input logic [7:0] d);
        return d & 8'h77;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000 && !done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
            summary();
        end
    end

    // drive at negedge, write lands at next posedge, return at following negedge
    task automatic reg_write(input logic [7:0] d);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    // count negedges until sck_ref is seen high
    task automatic wait_rise(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!sck_ref && n < 5000);
    endtask

    task automatic sweep_one(input int p, input int s, input logic [7:0] junk);
        int n, hi, lo, ticks;
        int h;
        logic [7:0] d;
        h = half_of(p, s);
        d = 8'(p << 4) | 8'(s) | (junk & 8'h88);
        reg_write(d);
        check(sck_ref == 1'b0, "R5 low after write", int'(sck_ref), 0);
        check(rd_data == exp_rd(d), "R2/R3 readback", int'(rd_data), int'(exp_rd(d)));
        wait_rise(n);
        check(n == h, "R5 first rise", n, h);
        hi = 0; lo = 0; ticks = 0;
        while (sck_ref && hi < 5000) begin
            @(negedge clk);
            hi++;
            if (baud_tick) ticks++;
        end
        while (!sck_ref && lo < 5000) begin
            @(negedge clk);
            lo++;
            if (baud_tick) ticks++;
        end
        check(hi == h, "R6 high time", hi, h);
        check(hi + lo == 2 * h, "R1 period", hi + lo, 2 * h);
        check(ticks == 1, "R7 ticks per period", ticks, 1);
    endtask

    initial begin
        int n, seen;
        void'($urandom(32'd715));
        rst = 1'b1; wr_en = 1'b0; wr_data = '0; run = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(rd_data == 8'h00, "R4 reset value", int'(rd_data), 0);
        check(sck_ref == 1'b0, "R8 idle low after reset", int'(sck_ref), 0);

        // R4: default divisor of 2
        run = 1'b1;
        wait_rise(n);
        check(n == 1, "R4 first rise at default", n, 1);
        @(negedge clk);
        check(sck_ref == 1'b0 && baud_tick == 1'b1, "R4 R7 default fall with tick",
              int'({sck_ref, baud_tick}), 1);
        @(negedge clk);
        check(sck_ref == 1'b1, "R4 period 2", int'(sck_ref), 1);

        // R3 corner: all reserved bits set, fields zero
        reg_write(8'h88);
        check(rd_data == 8'h00, "R3 reserved only", int'(rd_data), 0);
        reg_write(8'hFF);
        check(rd_data == 8'h77, "R3 all ones", int'(rd_data), 8'h77);

        // R1 R5 R6 R7 R9: full sweep while running, writes mid-transfer
        for (int p = 0; p < 8; p++) begin
            for (int s = 0; s < 8; s++) begin
                sweep_one(p, s, 8'($urandom));
            end
        end

        // R8 R9: random writes and run patterns
        for (int k = 0; k < 24; k++) begin
            logic [7:0] d;
            int h;
            d = 8'($urandom) & 8'hF3 | 8'h88;
            run = 1'b0;
            @(negedge clk);
            reg_write(d);
            check(rd_data == exp_rd(d), "R9 write while idle", int'(rd_data), int'(exp_rd(d)));
            seen = 0;
            for (int c = 0; c < 20; c++) begin
                @(negedge clk);
                if (sck_ref || baud_tick) seen++;
            end
            check(seen == 0, "R8 idle holds low", seen, 0);
            h = half_of(int'(d[6:4]), int'(d[2:0]));
            run = 1'b1;
            wait_rise(n);
            check(n == h, "R8 first rise after run", n, h);
        end

        run = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(sck_ref == 1'b0 && baud_tick == 1'b0, "R8 drop run", int'({sck_ref, baud_tick}), 0);
        summary();
    end

endmodule